// File: doc/BRIEF.md
# Scan-In Weighted Transition Meter

This block sits beside a scan chain and watches the serial bit stream entering it while a test vector loads. Every time two consecutively shifted bits differ, the mismatch will ripple through the remaining cells of the chain on every later shift. So the block adds a weight equal to the number of cells the transition still has to cross. The total is a data-dependent estimate of shift power for that one vector. It is compared with a programmable limit so that individual power-risky vectors can be picked out during pattern application.

A start strobe opens a vector and clears the position counter and the running sum. Each cycle with the shift enable high then accepts one scan bit. When exactly the chain length of bits has been accepted, the final sum and the risky verdict are latched and a one-cycle done pulse follows. The control is a three-state machine:
- **IDLE** waits for the start strobe.
- **LOAD** accepts bits.
- **FINISH** holds done for one cycle.

Its transitions are:
- IDLE→LOAD on start.
- LOAD→LOAD on start, which restarts the vector.
- LOAD→FINISH when the last bit is accepted.
- FINISH→LOAD on start.
- FINISH→IDLE otherwise.

Top module: `scan_wt_meter`

## Requirements
- R1: While reset is held and on leaving it, done and risky are 0 and the running and final sums are 0.
- R2: A start strobe in any state clears the running sum and the bit position, so a vector interrupted part-way is discarded and the next one is measured from its first bit.
- R3: A transition is a pair of consecutively accepted bits of the same vector with different values; the first bit of a vector never forms a transition, not even with the last bit of the vector before.
- R4: Bits are numbered 1 to CHAIN_LEN in shift order (bit 1 is shifted first). A transition between bits j and j+1 adds CHAIN_LEN − j to the running sum, so the running sum never decreases within a vector.
- R5: Only cycles in LOAD with the shift enable high and no start strobe accept a bit; idle cycles between shifts change neither the position nor the sum.
- R6: The cycle after the CHAIN_LEN-th accepted bit, done is high for exactly one cycle. At that point the final sum equals the running sum, and the final sum holds until the next vector completes.
- R7: Risky is updated only when done rises and is 1 exactly when the final sum is strictly greater than the threshold; a sum equal to the threshold is not risky.
- R8: Shift-enable cycles while in IDLE or FINISH are ignored: the sums, risky and done do not change.
- R9: When start and shift enable are high in the same cycle, start wins and that cycle's bit is dropped.
- R10: The sums are wide enough for the worst case CHAIN_LEN·(CHAIN_LEN−1)/2, reached by a fully alternating vector, and never exceed it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-vector strobe |
| shift_en_i | input | 1 | Shift enable; one bit is accepted per high cycle |
| scan_bit_i | input | 1 | Serial scan-in bit |
| thresh_i | input | SUM_W | Risk threshold, compared strictly greater |
| run_sum_o | output | SUM_W | Running weighted count of the current vector |
| final_sum_o | output | SUM_W | Weighted count of the last completed vector |
| done_o | output | 1 | One-cycle pulse after a vector completes |
| risky_o | output | 1 | Final sum exceeded the threshold |

## Verification
The bench builds the meter with CHAIN_LEN = 8, which gives a 5-bit sum and a maximum of 28. At that length every bit position is reachable in a few cycles. Each weight from 7 down to 1 can be produced in isolation. The worst-case alternating vector drives the sum to its ceiling, and thresholds of 27 and 28 put the strict-greater boundary exactly on that ceiling. The short chain also makes the following quick to reach: restarts part-way through a vector, a start coinciding with a shift, and stray shifts after completion.

// File: rtl/swtm_pkg.sv
package swtm_pkg;

    // Controller states of the weighted transition meter
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_FINISH = 2'd2
    } meter_state_t;

endpackage

// File: rtl/swtm_ctrl.sv
module swtm_ctrl
    import swtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic shift_en_i,
    input  logic last_i,
    output logic clear_o,
    output logic accept_o,
    output logic done_o
);

    meter_state_t state_q;
    meter_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (start_i)                      state_d = ST_LOAD;
                else if (shift_en_i && last_i)    state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (start_i) state_d = ST_LOAD;
                else         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        clear_o  = start_i;
        accept_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept_o = 1'b0;
            ST_LOAD:   accept_o = shift_en_i && !start_i;
            ST_FINISH: done_o   = 1'b1;
            default:   accept_o = 1'b0;
        endcase
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    no_accept_outside_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD) |-> !accept_o);

endmodule

// File: rtl/swtm_pos_track.sv
module swtm_pos_track #(
    parameter int LEN   = 16,
    parameter int CNT_W = $clog2(LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             prev_o,
    output logic             prev_valid_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] pos_q;
    logic             prev_q;
    logic             prev_valid_q;

    // Position counter and previous-bit register
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pos_q        <= '0;
            prev_q       <= 1'b0;
            prev_valid_q <= 1'b0;
        end else if (accept_i) begin
            pos_q        <= (pos_q == LAST_POS) ? '0 : pos_q + CNT_W'(1);
            prev_q       <= bit_i;
            prev_valid_q <= (pos_q != LAST_POS);
        end
    end

    assign pos_o        = pos_q;
    assign prev_o       = prev_q;
    assign prev_valid_o = prev_valid_q;
    assign last_o       = (pos_q == LAST_POS);

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

    // R3
    prev_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_valid_q == (pos_q != '0));

    // R5
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clear_i) |=> $stable(pos_q));

endmodule

// File: rtl/swtm_accum.sv
module swtm_accum #(
    parameter int LEN   = 16,
    parameter int CNT_W = $clog2(LEN + 1),
    parameter int SUM_W = $clog2(LEN * (LEN - 1) / 2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic             bit_i,
    input  logic             prev_i,
    input  logic             prev_valid_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic             last_i,
    input  logic [SUM_W-1:0] thresh_i,
    output logic [SUM_W-1:0] run_sum_o,
    output logic [SUM_W-1:0] final_sum_o,
    output logic             risky_o
);

    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(LEN * (LEN - 1) / 2);

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] final_q;
    logic             risky_q;
    logic [CNT_W-1:0] weight;
    logic             toggle;
    logic [SUM_W-1:0] inc;
    logic [SUM_W-1:0] acc_next;

    // Weight: cells still to be crossed by a transition found at this position
    always_comb begin
        weight   = CNT_W'(LEN) - pos_i;
        toggle   = accept_i && prev_valid_i && (bit_i != prev_i);
        inc      = toggle ? SUM_W'(weight) : '0;
        acc_next = acc_q + inc;
    end

    // Running accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            acc_q <= '0;
        end else if (accept_i) begin
            acc_q <= acc_next;
        end
    end

    // Completed-vector result and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            final_q <= '0;
            risky_q <= 1'b0;
        end else if (accept_i && last_i) begin
            final_q <= acc_next;
            risky_q <= (acc_next > thresh_i);
        end
    end

    assign run_sum_o   = acc_q;
    assign final_sum_o = final_q;
    assign risky_o     = risky_q;

    // R4
    run_sum_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (acc_q >= $past(acc_q)));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= MAX_SUM);

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q == '0));

endmodule

// File: rtl/scan_wt_meter.sv
module scan_wt_meter #(
    parameter int  CHAIN_LEN = 16,
    localparam int CNT_W     = $clog2(CHAIN_LEN + 1),
    localparam int SUM_W     = $clog2(CHAIN_LEN * (CHAIN_LEN - 1) / 2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             shift_en_i,
    input  logic             scan_bit_i,
    input  logic [SUM_W-1:0] thresh_i,
    output logic [SUM_W-1:0] run_sum_o,
    output logic [SUM_W-1:0] final_sum_o,
    output logic             done_o,
    output logic             risky_o
);

    logic             clear;
    logic             accept;
    logic             last;
    logic [CNT_W-1:0] pos;
    logic             prev;
    logic             prev_valid;

    swtm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .shift_en_i (shift_en_i),
        .last_i     (last),
        .clear_o    (clear),
        .accept_o   (accept),
        .done_o     (done_o)
    );

    swtm_pos_track #(
        .LEN   (CHAIN_LEN),
        .CNT_W (CNT_W)
    ) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .accept_i     (accept),
        .bit_i        (scan_bit_i),
        .pos_o        (pos),
        .prev_o       (prev),
        .prev_valid_o (prev_valid),
        .last_o       (last)
    );

    swtm_accum #(
        .LEN   (CHAIN_LEN),
        .CNT_W (CNT_W),
        .SUM_W (SUM_W)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .accept_i     (accept),
        .bit_i        (scan_bit_i),
        .prev_i       (prev),
        .prev_valid_i (prev_valid),
        .pos_i        (pos),
        .last_i       (last),
        .thresh_i     (thresh_i),
        .run_sum_o    (run_sum_o),
        .final_sum_o  (final_sum_o),
        .risky_o      (risky_o)
    );

    // R6
    final_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (final_sum_o == run_sum_o));

    // R7
    risky_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(risky_o) |-> done_o);

    // R6
    final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(final_sum_o) |-> done_o);

endmodule

// File: tb/sim_scan_wt_meter.sv
module sim_scan_wt_meter;

    localparam int L  = 8;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sen = 1'b0;
    logic          sbit = 1'b0;
    logic [SW-1:0] thr = '0;
    logic [SW-1:0] run_sum;
    logic [SW-1:0] final_sum;
    logic          done;
    logic          risky;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scan_wt_meter #(.CHAIN_LEN(L)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .shift_en_i  (sen),
        .scan_bit_i  (sbit),
        .thresh_i    (thr),
        .run_sum_o   (run_sum),
        .final_sum_o (final_sum),
        .done_o      (done),
        .risky_o     (risky)
    );

    // Reference: v[0] is bit 1 (shifted first); pair (j, j+1) weighs L - j
    function automatic int model(logic [L-1:0] v);
        int s = 0;
        for (int j = 1; j < L; j++) if (v[j] != v[j-1]) s += L - j;
        return s;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Shift n bits; optional idle cycle between bits; ends on the negedge after the last accepting edge
    task automatic shift_bits(logic [L-1:0] v, int n, bit gap, string req);
        int early = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (done) early++;
            sen  = 1'b1;
            sbit = v[i];
            if (gap && i < n - 1) begin
                @(negedge clk);
                if (done) early++;
                sen = 1'b0;
            end
        end
        @(negedge clk) sen = 1'b0;
        check({req, " no early done"}, early, 0);
    endtask

    task automatic finish_check(string req, int exp_sum, bit exp_risky);
        check({req, " done"}, int'(done), 1);
        check({req, " final"}, int'(final_sum), exp_sum);
        check({req, " run"}, int'(run_sum), exp_sum);
        check({req, " risky"}, int'(risky), int'(exp_risky));
        @(negedge clk);
        check({req, " done one cycle"}, int'(done), 0);
    endtask

    task automatic run_vec(string req, logic [L-1:0] v, int t, bit gap);
        thr = SW'(t);
        pulse_start();
        shift_bits(v, L, gap, req);
        finish_check(req, model(v), model(v) > t);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 run", int'(run_sum), 0);
        check("R1 final", int'(final_sum), 0);
        check("R1 risky", int'(risky), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_weights();
        run_vec("R4 first pair", 8'b0000_0001, 20, 1'b0);   // weight 7
        check("R4 first pair weight", int'(final_sum), 7);
        run_vec("R4 last pair", 8'b1000_0000, 20, 1'b0);    // weight 1
        check("R4 last pair weight", int'(final_sum), 1);
        run_vec("R4 mixed", 8'b0011_0110, 20, 1'b0);
        run_vec("R10 alternating", 8'b0101_0101, 20, 1'b0);
        check("R10 max sum", int'(final_sum), 28);
    endtask

    task automatic t_first_bit();
        // previous vector ended with 1; this one is all zeros
        run_vec("R3 no cross-vector", 8'b1000_0000, 20, 1'b0);
        run_vec("R3 all zero", 8'h00, 20, 1'b0);
        run_vec("R3 all one", 8'hFF, 20, 1'b0);
    endtask

    task automatic t_gaps();
        run_vec("R5 gapped", 8'b0101_0101, 20, 1'b1);
        run_vec("R5 gapped mixed", 8'b1110_0100, 20, 1'b1);
    endtask

    task automatic t_threshold();
        run_vec("R7 above", 8'b0101_0101, 27, 1'b0);
        run_vec("R7 tie", 8'b0101_0101, 28, 1'b0);
        run_vec("R7 zero tie", 8'h00, 0, 1'b0);
    endtask

    task automatic t_restart();
        thr = SW'(20);
        pulse_start();
        shift_bits(8'b0000_0110, 3, 1'b0, "R4 partial"); // bits 0,1,1 -> weight 7
        check("R4 partial run", int'(run_sum), 7);
        check("R6 no done partial", int'(done), 0);
        pulse_start();
        check("R2 cleared", int'(run_sum), 0);
        shift_bits(8'b1000_0000, L, 1'b0, "R2 restart");
        finish_check("R2 restart", 1, 1'b0);
    endtask

    task automatic t_ignore();
        logic [SW-1:0] r0;
        logic [SW-1:0] f0;
        run_vec("R8 setup", 8'b0011_0110, 5, 1'b0);
        r0 = run_sum;
        f0 = final_sum;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sen  = 1'b1;
            sbit = i[0];
        end
        @(negedge clk) sen = 1'b0;
        @(negedge clk);
        check("R8 run unchanged", int'(run_sum), int'(r0));
        check("R8 final unchanged", int'(final_sum), int'(f0));
        check("R8 no done", int'(done), 0);
        check("R8 risky held", int'(risky), 1);
    endtask

    task automatic t_start_with_shift();
        thr = SW'(20);
        @(negedge clk);
        start = 1'b1; sen = 1'b1; sbit = 1'b1;
        @(negedge clk);
        start = 1'b0; sen = 1'b0;
        shift_bits(8'h00, L, 1'b0, "R9");
        finish_check("R9 bit dropped", 0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_weights();
        t_first_bit();
        t_gaps();
        t_threshold();
        t_restart();
        t_ignore();
        t_start_with_shift();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule